// File: doc/BRIEF.md
# Timer Clock-Source Selector and Prescaler

This block is the input stage of a general-purpose timer. All of its logic runs on one internal clock. A pair of mode fields chooses what counts as a source tick. The choices are every internal clock cycle, an edge on one of two channel pins, or a rising edge on one of four internal trigger lines. The block divides those ticks by a programmable factor. The divided ticks advance a 16-bit up-counter.

The division ratio is double-buffered. Software writes a pending value, and that value reaches the active divider only at an update event. There are two kinds of update event. One is a counter wrap from all ones to zero. The other is a software update request, which also clears the divider phase and restarts the counter from zero. Pin and trigger inputs are asynchronous. Each one passes through a two-flop synchronizer, and its edges are then detected in the internal clock domain. Channel pins and trigger lines therefore give at most one tick per edge, and each pulse must stay stable for at least two internal clock cycles.

The register port has three addresses:
- Address 0 is control. Bit 0 is counter enable and bit 1 is the update request.
- Address 1 is mode. Bits 2:0 are the source mode and bits 6:4 are the trigger select.
- Address 2 is the pending prescaler value, 16 bits wide.

Top module: `tmr_clk_front`

## Requirements
- R1: With source mode 0 and enable (control bit 0) set, the counter advances once per internal clock cycle. With enable clear, the counter holds its value.
- R2: Source modes 4, 5 and 6 also count every internal clock cycle. Source modes 1, 2 and 3 give no ticks.
- R3: With source mode 7 and trigger select 0 to 3, each rising edge of trigger line N (where N equals the select value) gives one tick. Edges on other lines give none.
- R4: With source mode 7, trigger select 4 counts both edges of channel 0, select 5 counts rising edges of channel 0, select 6 counts rising edges of channel 1, and select 7 counts nothing.
- R5: The counter advances once per P+1 source ticks, where P is the active prescaler value. P = 0 passes every tick through.
- R6: A write to address 2 does not change the counting rate until the next update event.
- R7: Writing control bit 1 creates an update event on the following clock edge. On that edge the counter becomes 0, the divider phase clears, the pending prescaler value becomes active, and `upd_o` is high for exactly one cycle. The bit clears itself.
- R8: When a divided tick arrives with the counter at 0xFFFF, the counter wraps to 0 and `upd_o` pulses high for one cycle. On the same edge the pending prescaler value becomes active.
- R9: After reset the counter is 0, `upd_o` is low, enable is clear, the source mode is 0, and both prescaler values are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 mode, 2 prescaler) |
| wr_data | input | 16 | Register write data |
| ch0_i | input | 1 | Channel 0 pin, asynchronous |
| ch1_i | input | 1 | Channel 1 pin, asynchronous |
| trig_i | input | 4 | Internal trigger lines, asynchronous |
| cnt_o | output | 16 | Counter value |
| upd_o | output | 1 | One-cycle update event flag |

## Verification
A wrong active prescaler value or a stale divider phase shows up as a wrong count slope. This is visible within a few multiples of the division factor after an update event. A wrong source decode shows up as a counter that moves on the wrong pin or trigger line, three cycles after the offending edge reaches the pin. A missing shadow transfer shows up only at the next wrap or update request. For that reason the bench measures the rate both before and after each kind of update event, and it checks `upd_o` and the zeroed counter exactly one cycle after the request edge.

// File: rtl/tmr_fe_pkg.sv
package tmr_fe_pkg;
  typedef logic [2:0] fld3_t;

  // source mode codes
  localparam fld3_t SM_INTERNAL = 3'd0;
  localparam fld3_t SM_INT_A    = 3'd4;
  localparam fld3_t SM_INT_B    = 3'd5;
  localparam fld3_t SM_INT_C    = 3'd6;
  localparam fld3_t SM_EXTERNAL = 3'd7;

  // trigger select codes used in the external mode
  localparam fld3_t TS_CH0_BOTH = 3'd4;
  localparam fld3_t TS_CH0_RISE = 3'd5;
  localparam fld3_t TS_CH1_RISE = 3'd6;
endpackage

// File: rtl/tmr_fe_edge.sv
module tmr_fe_edge #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic         fall_lo
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] sq [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sq[i] <= '0;
    end else begin
      sq[0] <= din;
      for (int i = 1; i < DEPTH; i++) sq[i] <= sq[i-1];
    end
  end

  assign rise    = sq[STAGES-1] & ~sq[STAGES];
  assign fall_lo = ~sq[STAGES-1][0] & sq[STAGES][0];

  // a line cannot rise and fall in the same cycle (R4)
  assert_edge_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(rise[0] && fall_lo));
endmodule

// File: rtl/tmr_fe_srcsel.sv
module tmr_fe_srcsel import tmr_fe_pkg::*; #(
  parameter int NTRIG = 4
) (
  input  fld3_t            sm,
  input  fld3_t            ts,
  input  logic [1:0]       ch_rise,
  input  logic             ch0_fall,
  input  logic [NTRIG-1:0] trig_rise,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    case (sm)
      SM_INTERNAL, SM_INT_A, SM_INT_B, SM_INT_C: tick = 1'b1;
      SM_EXTERNAL: begin
        case (ts)
          TS_CH0_BOTH: tick = ch_rise[0] | ch0_fall;
          TS_CH0_RISE: tick = ch_rise[0];
          TS_CH1_RISE: tick = ch_rise[1];
          default: begin
            for (int i = 0; i < NTRIG; i++)
              if (ts == fld3_t'(i)) tick = trig_rise[i];
          end
        endcase
      end
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_fe_presc.sv
module tmr_fe_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cen,
  input  logic             src_tick,
  input  logic             load_we,
  input  logic [PSC_W-1:0] load_val,
  input  logic             reload,
  output logic             tick
);
  logic [PSC_W-1:0] shadow_q, act_q, div_q;
  logic             at_end;

  assign at_end = (div_q == act_q);
  assign tick   = cen & src_tick & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
      div_q    <= '0;
    end else begin
      if (load_we) shadow_q <= load_val;
      if (reload) begin
        act_q <= shadow_q;
        div_q <= '0;
      end else if (cen && src_tick) begin
        div_q <= at_end ? '0 : div_q + 1'b1;
      end
    end
  end

  // active ratio only moves on an update event (R6)
  assert_ratio_held_R6: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(act_q));
  // phase never passes the active ratio (R5)
  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (rst)
    div_q <= act_q);
endmodule

// File: rtl/tmr_clk_front.sv
module tmr_clk_front import tmr_fe_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int NTRIG       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ch0_i,
  input  logic              ch1_i,
  input  logic [NTRIG-1:0]  trig_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_o
);
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_PSC  = ADDR_W'(2);

  logic             cen_q, ug_q;
  fld3_t            sm_q, ts_q;
  logic [1:0]       ch_rise;
  logic             ch0_fall;
  logic [NTRIG-1:0] trig_rise;
  logic             src_tick, psc_tick, ev;
  logic [CNT_W-1:0] cnt_q;

  // register port
  always_ff @(posedge clk) begin
    if (rst) begin
      cen_q <= 1'b0;
      ug_q  <= 1'b0;
      sm_q  <= SM_INTERNAL;
      ts_q  <= '0;
    end else begin
      ug_q <= 1'b0;
      if (wr_en && wr_addr == ADR_CTRL) begin
        cen_q <= wr_data[0];
        ug_q  <= wr_data[1];
      end
      if (wr_en && wr_addr == ADR_MODE) begin
        sm_q <= wr_data[2:0];
        ts_q <= wr_data[6:4];
      end
    end
  end

  tmr_fe_edge #(.W(2), .STAGES(SYNC_STAGES)) u_ch_edge (
    .clk(clk), .rst(rst), .din({ch1_i, ch0_i}),
    .rise(ch_rise), .fall_lo(ch0_fall));

  logic trig_fall_unused;
  tmr_fe_edge #(.W(NTRIG), .STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst(rst), .din(trig_i),
    .rise(trig_rise), .fall_lo(trig_fall_unused));

  tmr_fe_srcsel #(.NTRIG(NTRIG)) u_sel (
    .sm(sm_q), .ts(ts_q), .ch_rise(ch_rise), .ch0_fall(ch0_fall),
    .trig_rise(trig_rise), .tick(src_tick));

  assign ev = ug_q | (psc_tick & (&cnt_q));

  tmr_fe_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .cen(cen_q), .src_tick(src_tick),
    .load_we(wr_en && wr_addr == ADR_PSC), .load_val(wr_data[PSC_W-1:0]),
    .reload(ev), .tick(psc_tick));

  // counter and update flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= ev;
      if (ev)            cnt_q <= '0;
      else if (psc_tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // an update event restarts the count and flags it (R7, R8)
  assert_update_restart_R7: assert property (@(posedge clk) disable iff (rst)
    ev |=> (cnt_q == '0) && upd_o);
  // without a divided tick or event the count holds (R1)
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!ev && !psc_tick) |=> $stable(cnt_q));
  // a divided tick needs the enable (R1)
  assert_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
    (!cen_q && !ug_q) |=> $stable(cnt_q));
endmodule

// File: tb/tmr_clk_front_test.sv
`timescale 1ns/1ps
module tmr_clk_front_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  lines = '0;   // 0 ch0, 1 ch1, 2..5 trig0..3
  logic [15:0] cnt_o;
  logic        upd_o;
  int          n_run = 0, n_fail = 0, cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tmr_clk_front uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch0_i(lines[0]), .ch1_i(lines[1]), .trig_i(lines[5:2]),
    .cnt_o(cnt_o), .upd_o(upd_o));

  // {sm[14:12], ts[10:8], line[6:4], expected[3:0]}; four pulses each
  localparam logic [15:0] VEC [12] = '{
    16'h7024,  // R3 trig0 counted
    16'h7030,  // R3 trig1 ignored under select 0
    16'h7134,  // R3 trig1
    16'h7244,  // R3 trig2
    16'h7354,  // R3 trig3
    16'h7300,  // R3 ch0 ignored under select 3
    16'h7408,  // R4 both edges of ch0
    16'h7504,  // R4 rising ch0
    16'h7510,  // R4 ch1 ignored under select 5
    16'h7614,  // R4 rising ch1
    16'h7700,  // R4 select 7 counts nothing
    16'h1020   // R2 mode 1 gives no ticks
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic slope(input int n, output int d);
    logic [15:0] a;
    a = cnt_o;
    repeat (n) @(negedge clk);
    d = int'(16'(cnt_o - a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 counter after reset", int'(cnt_o), 0);
    chk("R9 flag after reset", int'(upd_o), 0);
    slope(5, d);
    chk("R9 enable clear after reset", d, 0);

    // table walk, external sources at ratio 1
    foreach (VEC[i]) begin
      wr(2'd1, {9'd0, VEC[i][10:8], 1'b0, VEC[i][14:12]});
      wr(2'd0, 16'h0003);
      repeat (8) @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        lines[VEC[i][6:4]] = 1'b1;
        repeat (3) @(negedge clk);
        lines[VEC[i][6:4]] = 1'b0;
        repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk($sformatf("R3/R4 vector %0d", i), int'(cnt_o), int'(VEC[i][3:0]));
    end

    // R1 internal clock, enable on and off
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0001);
    slope(10, d); chk("R1 internal rate", d, 10);
    wr(2'd0, 16'h0000);
    slope(10, d); chk("R1 enable clear holds", d, 0);
    wr(2'd0, 16'h0001);

    // R2 other internal modes
    for (int m = 4; m <= 6; m++) begin
      wr(2'd1, 16'(m));
      slope(10, d); chk($sformatf("R2 mode %0d rate", m), d, 10);
    end
    wr(2'd1, 16'h0003);
    slope(10, d); chk("R2 mode 3 silent", d, 0);
    wr(2'd1, 16'h0000);

    // R6 pending ratio ignored, R5 ratio after update
    wr(2'd2, 16'd2);
    slope(12, d); chk("R6 old ratio kept", d, 12);
    wr(2'd0, 16'h0003);
    repeat (2) @(negedge clk);
    slope(30, d); chk("R5 divide by three", d, 10);

    // R7 update request: restart, flag, phase cleared
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0003);
    @(negedge clk);
    chk("R7 counter zero", int'(cnt_o), 0);
    chk("R7 flag high", int'(upd_o), 1);
    @(negedge clk);
    chk("R7 flag one cycle", int'(upd_o), 0);
    repeat (2) @(negedge clk);
    chk("R7 phase cleared, still zero", int'(cnt_o), 0);
    @(negedge clk);
    chk("R7 first divided tick", int'(cnt_o), 1);

    // R8 wrap with shadow transfer
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0003);
    wr(2'd2, 16'd1);
    for (int k = 0; k < 70000 && cnt_o != 16'hFFFF; k++) @(negedge clk);
    chk("R8 reached top", int'(cnt_o), 65535);
    @(negedge clk);
    chk("R8 wrap to zero", int'(cnt_o), 0);
    chk("R8 flag at wrap", int'(upd_o), 1);
    @(negedge clk);
    chk("R8 flag one cycle", int'(upd_o), 0);
    slope(10, d); chk("R8 ratio transferred", d, 5);

    finish_run();
  end
endmodule